// File: doc/BRIEF.md
# Audio Codec Mixer Control Register Bank

This block is the control register bank of a serial-link audio codec. Each frame of the link may carry one register command: an address, a read/write flag and sixteen bits of write data. The bank decodes that command against a fixed, sparse map of even addresses. It updates the addressed register or, for a read, captures the register's value so the next frame's status slots can return it.

The bank holds the volume and mute settings of every mixer path, the record source and gain, the power-down requests, the external amplifier shutdown control, the variable-rate enable and the two converter sample rates. Each register has its own reset value. It drives these settings straight to the analog mixer and the converters. Some fields are read-only: the converter and reference ready flags, the capability word and the vendor identification. Rate writes are accepted only while variable-rate operation is enabled, and any accepted rate is snapped to the nearest supported converter rate.

Top module: `ac_mixer_regs`

## Requirements
- R1: After reset the registers hold these values and outputs reflect them. 02h/04h/06h (master, line-level, mono) = 8000h, 0Ah = 0000h, 0Ch/0Eh = 8008h, 10h/12h/14h/16h/18h = 8808h (18h is the PCM-out volume), 1Ah = 0000h, 1Ch = 8000h, 20h/22h = 0000h, power and amplifier control clear, variable-rate enable clear, both rates = BB80h (48000).
- R2: A read command (cmd_valid=1, cmd_rd=1) produces rsp_valid high for exactly the following cycle, with rsp_addr equal to the command address and rsp_data equal to the register content at the command cycle.
- R3: Addresses outside the map, including every odd address, read as 0000h, and writes to them change nothing.
- R4: Reading 00h returns the RESET_CAPS parameter; any write to 00h returns every writable register to its R1 value on the next cycle.
- R5: The fifteen volume, record and general registers store all 16 bits written; bit 15 is the mute flag; master_vol, lnlvl_vol, mono_vol and pcm_vol show 02h, 04h, 06h and 18h.
- R6: At 26h, bit 15 is the amplifier shutdown control (amp_pdn) and bits 14:8 are power-down requests 6..0 (pdn_req); bits 3:0 read the live ready inputs (bit 3 reference, bit 2 analog mixer, bit 1 DAC, bit 0 ADC) and cannot be written; other bits read 0.
- R7: 28h is read-only and reads {codec_id[1:0], 13'b0, 1'b1}, bit 0 reporting variable-rate support.
- R8: At 2Ah only bit 0 (variable-rate enable) is stored; other bits read 0.
- R9: While the variable-rate enable is 0, writes to 2Ch (DAC rate) and 32h (ADC rate) are dropped, and both rate registers and the dac_rate/adc_rate outputs show BB80h; a value stored earlier shows again once the enable is set.
- R10: An accepted rate write stores the nearest of 8000, 11025, 16000, 22050, 44100, 48000; a value exactly midway between two rates takes the lower one, and anything above 46050 gives 48000.
- R11: 7Ch and 7Eh read the VENDOR_ID1 and VENDOR_ID2 parameters; writes there change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | A register command is present this cycle |
| cmd_rd | input | 1 | 1 = read, 0 = write |
| cmd_addr | input | 7 | Register address |
| cmd_wdata | input | 16 | Write data |
| rdy_status | input | 4 | Ready flags: reference, analog, DAC, ADC (bits 3..0) |
| codec_id | input | 2 | Codec identity reported at 28h |
| rsp_valid | output | 1 | Read response present |
| rsp_addr | output | 7 | Address being answered |
| rsp_data | output | 16 | Read data for the status slot |
| master_vol | output | 16 | Master volume register |
| lnlvl_vol | output | 16 | Line-level output volume register |
| mono_vol | output | 16 | Mono output volume register |
| pcm_vol | output | 16 | PCM-out volume register |
| pdn_req | output | 7 | Power-down requests 6..0 |
| amp_pdn | output | 1 | External amplifier shutdown |
| dac_rate | output | 16 | Effective DAC sample rate |
| adc_rate | output | 16 | Effective ADC sample rate |

## Verification
Two pairs of functions meet in one cycle here. A read of 26h returns ready flags that may change in that same cycle, and a write to 26h carries ones into the read-only ready positions while the flags move. The bench changes rdy_status on the very cycle of a full-ones write to 26h and then reads 26h back. It expects the written control bits together with the flag values present at the read's own cycle. The second pair is the rate gating against the enable. Rate writes are issued before and after the enable flips, and the enable is then cleared again, so that the stored value, the clamped value and the forced 48000 can each be told apart at both the read port and the rate outputs.

// File: rtl/mixreg_pkg.sv
package mixreg_pkg;
  localparam int ADDR_W  = 7;
  localparam int DATA_W  = 16;
  localparam int NUM_VOL = 15;
  localparam int NUM_PR  = 7;
  localparam int NUM_RDY = 4;
  localparam int NUM_RATE = 2;
  localparam logic [DATA_W-1:0] RATE_MAX = 16'd48000;

  // Address of each generic read/write register, by slot index.
  function automatic logic [ADDR_W-1:0] vol_addr(input int i);
    case (i)
      0: return 7'h02;  1: return 7'h04;  2: return 7'h06;
      3: return 7'h0A;  4: return 7'h0C;  5: return 7'h0E;
      6: return 7'h10;  7: return 7'h12;  8: return 7'h14;
      9: return 7'h16; 10: return 7'h18; 11: return 7'h1A;
      12: return 7'h1C; 13: return 7'h20; 14: return 7'h22;
      default: return 7'h7F;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] vol_default(input int i);
    case (i)
      0, 1, 2, 12:        return 16'h8000;
      4, 5:               return 16'h8008;
      6, 7, 8, 9, 10:     return 16'h8808;
      default:            return 16'h0000;
    endcase
  endfunction

  function automatic logic rate_ok(input logic [DATA_W-1:0] r);
    return (r == 16'd8000) || (r == 16'd11025) || (r == 16'd16000) ||
           (r == 16'd22050) || (r == 16'd44100) || (r == 16'd48000);
  endfunction
endpackage

// File: rtl/mixreg_decode.sv
module mixreg_decode
  import mixreg_pkg::*;
(
  input  logic [ADDR_W-1:0]  addr,
  output logic [NUM_VOL-1:0] sel_vol,
  output logic               sel_caps,
  output logic               sel_pwr,
  output logic               sel_extid,
  output logic               sel_extctl,
  output logic [NUM_RATE-1:0] sel_rate,
  output logic               sel_vid1,
  output logic               sel_vid2
);
  for (genvar g = 0; g < NUM_VOL; g++) begin : g_vol_sel
    assign sel_vol[g] = (addr == vol_addr(g));
  end

  assign sel_caps    = (addr == 7'h00);
  assign sel_pwr     = (addr == 7'h26);
  assign sel_extid   = (addr == 7'h28);
  assign sel_extctl  = (addr == 7'h2A);
  assign sel_rate[0] = (addr == 7'h2C);
  assign sel_rate[1] = (addr == 7'h32);
  assign sel_vid1    = (addr == 7'h7C);
  assign sel_vid2    = (addr == 7'h7E);
endmodule

// File: rtl/mixreg_rate_clamp.sv
module mixreg_rate_clamp
  import mixreg_pkg::*;
(
  input  logic [DATA_W-1:0] req,
  output logic [DATA_W-1:0] rate
);
  // Midpoints between neighbouring rates; a tie resolves downward.
  always_comb begin
    if      (req <= 16'd9512)  rate = 16'd8000;
    else if (req <= 16'd13512) rate = 16'd11025;
    else if (req <= 16'd19025) rate = 16'd16000;
    else if (req <= 16'd33075) rate = 16'd22050;
    else if (req <= 16'd46050) rate = 16'd44100;
    else                       rate = RATE_MAX;
  end
endmodule

// File: rtl/ac_mixer_regs.sv
module ac_mixer_regs
  import mixreg_pkg::*;
#(
  parameter logic [DATA_W-1:0] RESET_CAPS = 16'h0000,
  parameter logic [DATA_W-1:0] VENDOR_ID1 = 16'hA5C3,
  parameter logic [DATA_W-1:0] VENDOR_ID2 = 16'h0101
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic               cmd_rd,
  input  logic [ADDR_W-1:0]  cmd_addr,
  input  logic [DATA_W-1:0]  cmd_wdata,
  input  logic [NUM_RDY-1:0] rdy_status,
  input  logic [1:0]         codec_id,
  output logic               rsp_valid,
  output logic [ADDR_W-1:0]  rsp_addr,
  output logic [DATA_W-1:0]  rsp_data,
  output logic [DATA_W-1:0]  master_vol,
  output logic [DATA_W-1:0]  lnlvl_vol,
  output logic [DATA_W-1:0]  mono_vol,
  output logic [DATA_W-1:0]  pcm_vol,
  output logic [NUM_PR-1:0]  pdn_req,
  output logic               amp_pdn,
  output logic [DATA_W-1:0]  dac_rate,
  output logic [DATA_W-1:0]  adc_rate
);
  localparam int PWR_W = NUM_PR + 1;
  localparam int PCM_IDX = 10;

  // Reset synchronizer: assert asynchronously, release on the clock.
  logic rst_meta_q, rst_n_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_n_q    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_q    <= rst_meta_q;
    end
  end

  logic [NUM_VOL-1:0]  sel_vol;
  logic [NUM_RATE-1:0] sel_rate;
  logic sel_caps, sel_pwr, sel_extid, sel_extctl, sel_vid1, sel_vid2;

  mixreg_decode u_dec (
    .addr(cmd_addr), .sel_vol(sel_vol), .sel_caps(sel_caps), .sel_pwr(sel_pwr),
    .sel_extid(sel_extid), .sel_extctl(sel_extctl), .sel_rate(sel_rate),
    .sel_vid1(sel_vid1), .sel_vid2(sel_vid2)
  );

  logic [DATA_W-1:0] clamp_rate;
  mixreg_rate_clamp u_clamp (.req(cmd_wdata), .rate(clamp_rate));

  logic wr_en, rd_en, soft_rst;
  assign wr_en    = cmd_valid & ~cmd_rd;
  assign rd_en    = cmd_valid & cmd_rd;
  assign soft_rst = wr_en & sel_caps;

  logic [DATA_W-1:0] vol_q  [NUM_VOL];
  logic [DATA_W-1:0] vol_d  [NUM_VOL];
  logic [DATA_W-1:0] rate_q [NUM_RATE];
  logic [DATA_W-1:0] rate_d [NUM_RATE];
  logic [DATA_W-1:0] rate_eff [NUM_RATE];
  logic [PWR_W-1:0]  pwr_q, pwr_d;
  logic              vra_q, vra_d;

  // Next-state logic.
  always_comb begin
    for (int i = 0; i < NUM_VOL; i++) vol_d[i] = vol_q[i];
    for (int c = 0; c < NUM_RATE; c++) rate_d[c] = rate_q[c];
    pwr_d = pwr_q;
    vra_d = vra_q;
    if (soft_rst) begin
      for (int i = 0; i < NUM_VOL; i++) vol_d[i] = vol_default(i);
      for (int c = 0; c < NUM_RATE; c++) rate_d[c] = RATE_MAX;
      pwr_d = '0;
      vra_d = 1'b0;
    end else if (wr_en) begin
      for (int i = 0; i < NUM_VOL; i++)
        if (sel_vol[i]) vol_d[i] = cmd_wdata;
      for (int c = 0; c < NUM_RATE; c++)
        if (sel_rate[c] && vra_q) rate_d[c] = clamp_rate;
      if (sel_pwr)    pwr_d = cmd_wdata[DATA_W-1 -: PWR_W];
      if (sel_extctl) vra_d = cmd_wdata[0];
    end
  end

  // State registers, enabled by write commands only.
  always_ff @(posedge clk or negedge rst_n_q) begin
    if (!rst_n_q) begin
      for (int i = 0; i < NUM_VOL; i++) vol_q[i] <= vol_default(i);
      for (int c = 0; c < NUM_RATE; c++) rate_q[c] <= RATE_MAX;
      pwr_q <= '0;
      vra_q <= 1'b0;
    end else if (wr_en) begin
      for (int i = 0; i < NUM_VOL; i++) vol_q[i] <= vol_d[i];
      for (int c = 0; c < NUM_RATE; c++) rate_q[c] <= rate_d[c];
      pwr_q <= pwr_d;
      vra_q <= vra_d;
    end
  end

  for (genvar c = 0; c < NUM_RATE; c++) begin : g_rate_eff
    assign rate_eff[c] = vra_q ? rate_q[c] : RATE_MAX;
  end

  // Read multiplexer.
  logic [DATA_W-1:0] rd_data;
  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_VOL; i++)
      if (sel_vol[i]) rd_data = vol_q[i];
    for (int c = 0; c < NUM_RATE; c++)
      if (sel_rate[c]) rd_data = rate_eff[c];
    if (sel_caps)   rd_data = RESET_CAPS;
    if (sel_pwr)    rd_data = {pwr_q, {(DATA_W-PWR_W-NUM_RDY){1'b0}}, rdy_status};
    if (sel_extid)  rd_data = {codec_id, {(DATA_W-3){1'b0}}, 1'b1};
    if (sel_extctl) rd_data = {{(DATA_W-1){1'b0}}, vra_q};
    if (sel_vid1)   rd_data = VENDOR_ID1;
    if (sel_vid2)   rd_data = VENDOR_ID2;
  end

  logic              rsp_valid_q;
  logic [ADDR_W-1:0] rsp_addr_q;
  logic [DATA_W-1:0] rsp_data_q;
  always_ff @(posedge clk or negedge rst_n_q) begin
    if (!rst_n_q) begin
      rsp_valid_q <= 1'b0;
      rsp_addr_q  <= '0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= rd_en;
      if (rd_en) begin
        rsp_addr_q <= cmd_addr;
        rsp_data_q <= rd_data;
      end
    end
  end

  assign rsp_valid  = rsp_valid_q;
  assign rsp_addr   = rsp_addr_q;
  assign rsp_data   = rsp_data_q;
  assign master_vol = vol_q[0];
  assign lnlvl_vol  = vol_q[1];
  assign mono_vol   = vol_q[2];
  assign pcm_vol    = vol_q[PCM_IDX];
  assign pdn_req    = pwr_q[NUM_PR-1:0];
  assign amp_pdn    = pwr_q[PWR_W-1];
  assign dac_rate   = rate_eff[0];
  assign adc_rate   = rate_eff[1];
endmodule

// File: rtl/mixreg_checker.sv
module mixreg_checker
  import mixreg_pkg::*;
(
  input logic               clk,
  input logic               rst_ni,
  input logic               cmd_valid,
  input logic               cmd_rd,
  input logic [ADDR_W-1:0]  cmd_addr,
  input logic               vra_q,
  input logic               rsp_valid,
  input logic [ADDR_W-1:0]  rsp_addr,
  input logic [DATA_W-1:0]  rsp_data,
  input logic [DATA_W-1:0]  master_vol,
  input logic [DATA_W-1:0]  pcm_vol,
  input logic [NUM_PR-1:0]  pdn_req,
  input logic [DATA_W-1:0]  dac_rate,
  input logic [DATA_W-1:0]  adc_rate
);
  p_rsp_after_read_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    (cmd_valid && cmd_rd) |=> (rsp_valid && rsp_addr == $past(cmd_addr)));

  p_no_rsp_without_read_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    !(cmd_valid && cmd_rd) |=> !rsp_valid);

  p_unmapped_reads_zero_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (cmd_valid && cmd_rd && cmd_addr[0]) |=> (rsp_data == '0));

  p_soft_reset_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (cmd_valid && !cmd_rd && cmd_addr == 7'h00) |=>
      (master_vol == 16'h8000 && pcm_vol == 16'h8808 && pdn_req == '0 &&
       dac_rate == RATE_MAX && adc_rate == RATE_MAX));

  p_rate_gated_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    (cmd_valid && !cmd_rd && cmd_addr == 7'h2C && !vra_q) |=> $stable(dac_rate));

  p_rates_supported_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    rate_ok(dac_rate) && rate_ok(adc_rate));
endmodule

bind ac_mixer_regs mixreg_checker u_chk (
  .clk(clk), .rst_ni(rst_n_q), .cmd_valid(cmd_valid), .cmd_rd(cmd_rd),
  .cmd_addr(cmd_addr), .vra_q(vra_q), .rsp_valid(rsp_valid),
  .rsp_addr(rsp_addr), .rsp_data(rsp_data), .master_vol(master_vol),
  .pcm_vol(pcm_vol), .pdn_req(pdn_req), .dac_rate(dac_rate), .adc_rate(adc_rate)
);

// File: tb/tb_ac_mixer_regs.sv
module tb_ac_mixer_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_rd = 1'b0;
  logic [6:0]  cmd_addr = '0;
  logic [15:0] cmd_wdata = '0;
  logic [3:0]  rdy_status = 4'b0000;
  logic [1:0]  codec_id = 2'b10;
  logic        rsp_valid, amp_pdn;
  logic [6:0]  rsp_addr, pdn_req;
  logic [15:0] rsp_data, master_vol, lnlvl_vol, mono_vol, pcm_vol, dac_rate, adc_rate;

  localparam logic [15:0] VID1 = 16'h3C5A;
  localparam logic [15:0] VID2 = 16'h0E11;
  localparam logic [15:0] CAPS = 16'h0040;

  ac_mixer_regs #(.RESET_CAPS(CAPS), .VENDOR_ID1(VID1), .VENDOR_ID2(VID2)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_rd(cmd_rd),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .rdy_status(rdy_status),
    .codec_id(codec_id), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
    .rsp_data(rsp_data), .master_vol(master_vol), .lnlvl_vol(lnlvl_vol),
    .mono_vol(mono_vol), .pcm_vol(pcm_vol), .pdn_req(pdn_req), .amp_pdn(amp_pdn),
    .dac_rate(dac_rate), .adc_rate(adc_rate)
  );

  always #5 clk = ~clk;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [6:0]  q_addr[$];
  logic [15:0] q_data[$];
  string       q_tag[$];

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [15:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_rd = 1'b0; cmd_addr = a; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk);
    q_addr.push_back(a); q_data.push_back(exp); q_tag.push_back(tag);
    cmd_valid = 1'b1; cmd_rd = 1'b1; cmd_addr = a; cmd_wdata = 16'hDEAD;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // Monitor: each response must match the oldest expected read.
  always @(negedge clk) begin
    if (rsp_valid) begin
      if (q_tag.size() == 0) begin
        n_run++; n_fail++;
        $display("FAIL R2: unexpected response actual %h expected none", rsp_data);
      end else begin
        logic [6:0] ea; logic [15:0] ed; string et;
        ea = q_addr.pop_front(); ed = q_data.pop_front(); et = q_tag.pop_front();
        check({et, " addr"}, {9'd0, rsp_addr}, {9'd0, ea});
        check(et, rsp_data, ed);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [6:0]  va [15];
    logic [15:0] vd [15];
    va = '{7'h02,7'h04,7'h06,7'h0A,7'h0C,7'h0E,7'h10,7'h12,7'h14,7'h16,7'h18,7'h1A,7'h1C,7'h20,7'h22};
    vd = '{16'h8000,16'h8000,16'h8000,16'h0000,16'h8008,16'h8008,16'h8808,16'h8808,
           16'h8808,16'h8808,16'h8808,16'h0000,16'h8000,16'h0000,16'h0000};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset values at the outputs and through reads
    check("R1 master", master_vol, 16'h8000);
    check("R1 lnlvl", lnlvl_vol, 16'h8000);
    check("R1 mono", mono_vol, 16'h8000);
    check("R1 pcm", pcm_vol, 16'h8808);
    check("R1 pdn", {8'd0, amp_pdn, pdn_req}, 16'h0000);
    check("R1 dac", dac_rate, 16'hBB80);
    check("R1 adc", adc_rate, 16'hBB80);
    check("R2 idle", {15'd0, rsp_valid}, 16'h0000);
    for (int i = 0; i < 15; i++) rd(va[i], vd[i], "R1 default");
    rd(7'h2A, 16'h0000, "R1 vra");
    rd(7'h2C, 16'hBB80, "R1 dac rd");
    rd(7'h32, 16'hBB80, "R1 adc rd");

    // R3: unmapped and odd addresses
    rd(7'h08, 16'h0000, "R3 hole");
    rd(7'h24, 16'h0000, "R3 hole24");
    rd(7'h03, 16'h0000, "R3 odd");
    wr(7'h08, 16'h1234);
    wr(7'h03, 16'h5555);
    rd(7'h08, 16'h0000, "R3 hole wr");
    rd(7'h02, 16'h8000, "R3 odd wr");

    // R5: full-width volume storage
    wr(7'h02, 16'h1F1F);
    check("R5 master", master_vol, 16'h1F1F);
    wr(7'h18, 16'h0A05);
    check("R5 pcm", pcm_vol, 16'h0A05);
    wr(7'h06, 16'h801F);
    check("R5 mono mute", mono_vol, 16'h801F);
    rd(7'h02, 16'h1F1F, "R5 rd");
    rd(7'h1C, 16'h8000, "R5 neighbour");

    // R6: power register while ready flags move on the write cycle
    @(negedge clk);
    rdy_status = 4'b1010;
    cmd_valid = 1'b1; cmd_rd = 1'b0; cmd_addr = 7'h26; cmd_wdata = 16'hFFFF;
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R6 pdn", {9'd0, pdn_req}, 16'h007F);
    check("R6 amp", {15'd0, amp_pdn}, 16'h0001);
    rd(7'h26, 16'hFF0A, "R6 rd");
    rdy_status = 4'b0101;
    rd(7'h26, 16'hFF05, "R6 live");
    wr(7'h26, 16'h2500);
    check("R6 amp clr", {8'd0, amp_pdn, pdn_req}, 16'h0025);

    // R7: read-only identity
    rd(7'h28, 16'h8001, "R7 id");
    wr(7'h28, 16'h0000);
    codec_id = 2'b01;
    rd(7'h28, 16'h4001, "R7 ro");

    // R9: rate writes dropped while the enable is clear
    wr(7'h2C, 16'd8000);
    check("R9 dac gated", dac_rate, 16'hBB80);
    rd(7'h2C, 16'hBB80, "R9 rd");
    // R8: only bit 0 of 2Ah stored
    wr(7'h2A, 16'hFFFF);
    rd(7'h2A, 16'h0001, "R8 vra");
    rd(7'h2C, 16'hBB80, "R9 earlier write lost");

    // R10: clamping
    wr(7'h2C, 16'd8000);   check("R10 8000", dac_rate, 16'd8000);
    wr(7'h2C, 16'd9512);   check("R10 tie low", dac_rate, 16'd8000);
    wr(7'h2C, 16'd9513);   check("R10 9513", dac_rate, 16'd11025);
    wr(7'h2C, 16'd33075);  check("R10 tie 33075", dac_rate, 16'd22050);
    wr(7'h2C, 16'd33076);  check("R10 33076", dac_rate, 16'd44100);
    wr(7'h2C, 16'd46050);  check("R10 tie 46050", dac_rate, 16'd44100);
    wr(7'h2C, 16'd46051);  check("R10 46051", dac_rate, 16'd48000);
    wr(7'h2C, 16'd0);      check("R10 zero", dac_rate, 16'd8000);
    wr(7'h2C, 16'hFFFF);   check("R10 max", dac_rate, 16'd48000);
    wr(7'h32, 16'd16000);  check("R10 adc", adc_rate, 16'd16000);
    wr(7'h2C, 16'd11000);
    rd(7'h2C, 16'd11025, "R10 rd");

    // R9: clearing the enable forces 48000, setting it restores
    wr(7'h2A, 16'h0000);
    check("R9 dac off", dac_rate, 16'hBB80);
    check("R9 adc off", adc_rate, 16'hBB80);
    rd(7'h32, 16'hBB80, "R9 adc rd");
    wr(7'h2A, 16'h0001);
    check("R9 restore", adc_rate, 16'd16000);

    // R11: vendor words
    rd(7'h7C, VID1, "R11 id1");
    rd(7'h7E, VID2, "R11 id2");
    wr(7'h7C, 16'h0000);
    rd(7'h7C, VID1, "R11 ro");

    // R4: capability read, then soft reset
    rd(7'h00, CAPS, "R4 caps");
    wr(7'h00, 16'h0000);
    check("R4 master", master_vol, 16'h8000);
    check("R4 pcm", pcm_vol, 16'h8808);
    check("R4 mono", mono_vol, 16'h8000);
    check("R4 pdn", {8'd0, amp_pdn, pdn_req}, 16'h0000);
    check("R4 adc", adc_rate, 16'hBB80);
    rd(7'h2A, 16'h0000, "R4 vra");
    wr(7'h2A, 16'h0001);
    rd(7'h32, 16'hBB80, "R4 rate cleared");

    repeat (3) @(negedge clk);
    check("R2 drained", 16'(q_tag.size()), 16'h0000);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule